// File: doc/BRIEF.md
# Multiplexed Four-Digit Display Scanner

The scanner drives a time-multiplexed seven-segment display and a shared BCD output bus from a set of latched decimal digits. A short scan pulse steps a phase counter that selects one digit at a time. The order runs from the most significant digit down to the least significant digit and then starts again. For the selected digit the block raises one digit enable, drives that digit's segment pattern and places its BCD nibble on the bus. While the scan pulse is high every digit enable is held low, so the display is blank between digits and does not ghost.

Two control pins change how the scan runs. A display-off request freezes the phase, turns off all digit and segment lines and releases the BCD bus. A load-mode flag tells the block that a preset sequence is in progress. In that mode the phase counter follows an internal free-running tick instead of the external scan pulse, and the BCD bus is released so that data can be driven onto it from outside.

All pins are plain level signals. The stream handshake of the house style is not used, because no data item is transferred. The bus output-enable plays the role of the tri-state control.

Top module: `disp_scan`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the phase to the most significant digit, index NDIG-1. With no pulse afterwards, dig_en is one-hot at bit NDIG-1.
- R2: The active pulse is scan_tick in normal mode and free_tick in load mode. Each rising edge of the active pulse, seen at a clock edge, moves the phase one step down (NDIG-1, ..., 1, 0, then NDIG-1 again). The new digit appears on the outputs in the cycle after that edge.
- R3: While the active pulse is high, every bit of dig_en is 0. This gives the blanking between digits.
- R4: An active pulse held high for several cycles advances the phase only once.
- R5: Digit k sits in bits [4k+3:4k] of digits. bcd_out always shows the nibble of the selected digit. bcd_oe is 1 only when disp_off and load_mode are both 0.
- R6: seg is active high with bit order {g,f,e,d,c,b,a}. Values 0 to 9 give the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Values 10 to 15 give 00.
- R7: While disp_off is 1, dig_en, seg and bcd_oe are all 0 and the phase does not move. When disp_off returns to 0, the scan continues from the digit it held.
- R8: In load mode, scan_tick has no effect on the phase or on blanking. free_tick is used in its place, and bcd_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | External scan pulse |
| free_tick | input | 1 | Internal free-running scan pulse, used in load mode |
| digits | input | 4*NDIG | Latched digits, digit k in bits [4k+3:4k] |
| disp_off | input | 1 | Display-off request |
| load_mode | input | 1 | Load sequence in progress |
| dig_en | output | NDIG | Digit enables, active high |
| seg | output | 7 | Segment lines {g,f,e,d,c,b,a}, active high |
| bcd_out | output | 4 | BCD nibble of the selected digit |
| bcd_oe | output | 1 | Output enable for the BCD bus |

## Verification
The bench builds the block with the default NDIG of 4. With that value the wrap from digit 0 back to digit 3 comes round after four pulses. This lets a single run cross it many times, including while the display is off and while load mode is active. Because the nibble width is four bits, the bench can feed all sixteen codes through the selected-digit path, which exercises both the ten decoded patterns and the six blank codes.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;

  // segment order {g,f,e,d,c,b,a}, active high; non-decimal codes are blank
  function automatic logic [SEG_W-1:0] nib_to_seg(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_phase.sv
module scan_phase #(
  parameter int NDIG = 4,
  localparam int PW = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  output logic [PW-1:0] phase
);
  logic tick_q;
  logic rise;

  assign rise = tick & ~tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      phase  <= PW'(NDIG - 1);
    end else begin
      tick_q <= tick;
      if (rise && !hold)
        phase <= (phase == '0) ? PW'(NDIG - 1) : phase - 1'b1;
    end
  end

  // R2: the phase index never leaves the digit range
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < NDIG);
  // R2: an accepted rising edge moves the phase to a new digit
  assert_step_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !hold) |=> phase != $past(phase));
  // R4: a level that stays high does not step again
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && tick) |=> $stable(phase));
  // R7: a held scan keeps its phase
  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(phase));
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int NDIG = 4,
  localparam int PW = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int NW = disp_scan_pkg::NIB_W
) (
  input  logic [NDIG*NW-1:0] digits,
  input  logic [PW-1:0]      phase,
  output logic [NW-1:0]      nibble
);
  always_comb begin
    nibble = '0;
    for (int k = 0; k < NDIG; k++)
      if (int'(phase) == k) nibble = digits[k*NW +: NW];
  end
endmodule

// File: rtl/seg_drive.sv
module seg_drive (
  input  logic [disp_scan_pkg::NIB_W-1:0] nibble,
  input  logic                            blank,
  output logic [disp_scan_pkg::SEG_W-1:0] seg
);
  assign seg = blank ? '0 : disp_scan_pkg::nib_to_seg(nibble);
endmodule

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int NDIG = 4,
  localparam int PW = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int NW = disp_scan_pkg::NIB_W,
  localparam int SW = disp_scan_pkg::SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_tick,
  input  logic              free_tick,
  input  logic [NDIG*NW-1:0] digits,
  input  logic              disp_off,
  input  logic              load_mode,
  output logic [NDIG-1:0]   dig_en,
  output logic [SW-1:0]     seg,
  output logic [NW-1:0]     bcd_out,
  output logic              bcd_oe
);
  logic          act_tick;
  logic [PW-1:0] phase;

  assign act_tick = load_mode ? free_tick : scan_tick;

  scan_phase #(.NDIG(NDIG)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(act_tick), .hold(disp_off), .phase(phase)
  );

  digit_select #(.NDIG(NDIG)) u_sel (
    .digits(digits), .phase(phase), .nibble(bcd_out)
  );

  seg_drive u_seg (.nibble(bcd_out), .blank(disp_off), .seg(seg));

  for (genvar k = 0; k < NDIG; k++) begin : g_en
    assign dig_en[k] = (int'(phase) == k) && !act_tick && !disp_off;
  end

  assign bcd_oe = !disp_off && !load_mode;

  // R2: at most one digit is lit at any time
  assert_one_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_en));
  // R3: blanking while the active pulse is high
  assert_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_tick |-> dig_en == '0);
  // R7: display off leaves every driver released
  assert_off_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> (seg == '0 && dig_en == '0 && !bcd_oe));
  // R8: the bus is released during load
  assert_load_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |-> !bcd_oe);
endmodule

// File: tb/tb_disp_scan.sv
module tb_disp_scan;
  localparam int NDIG = 4;

  logic clk = 1'b0;
  logic rst_n, scan_tick, free_tick, disp_off, load_mode;
  logic [NDIG*4-1:0] digits;
  logic [NDIG-1:0] dig_en;
  logic [6:0] seg;
  logic [3:0] bcd_out;
  logic bcd_oe;

  always #2.5 clk = ~clk;

  disp_scan #(.NDIG(NDIG)) dut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .free_tick(free_tick),
    .digits(digits), .disp_off(disp_off), .load_mode(load_mode),
    .dig_en(dig_en), .seg(seg), .bcd_out(bcd_out), .bcd_oe(bcd_oe)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  // next-cycle stimulus
  logic nx_rst = 0, nx_scan = 0, nx_free = 0, nx_off = 0, nx_load = 0;
  logic [NDIG*4-1:0] nx_dig = '0;
  // reference model state
  int m_phase = NDIG - 1;
  logic m_prev = 0;

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v < 10) ? t[v] : 7'h00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic act;
    logic [3:0] nib;
    logic [NDIG-1:0] een;
    @(negedge clk);
    rst_n = nx_rst; scan_tick = nx_scan; free_tick = nx_free;
    disp_off = nx_off; load_mode = nx_load; digits = nx_dig;
    #1;
    act = load_mode ? free_tick : scan_tick;
    nib = digits[m_phase*4 +: 4];
    een = '0;
    if (!act && !disp_off) een[m_phase] = 1'b1;
    if (rst_n) begin
      chk(disp_off ? "R7 dig_en" : (act ? "R3 dig_en" : "R2 dig_en"), dig_en, een);
      chk(disp_off ? "R7 seg" : "R6 seg", seg, disp_off ? 7'h00 : ref_seg(nib));
      chk("R5 bcd_out", bcd_out, nib);
      chk(load_mode ? "R8 bcd_oe" : "R5 bcd_oe", bcd_oe, !disp_off && !load_mode);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_phase = NDIG - 1; m_prev = 0;
    end else begin
      if (act && !m_prev && !disp_off) m_phase = (m_phase == 0) ? NDIG - 1 : m_phase - 1;
      m_prev = act;
    end
  endtask

  task automatic run(input int n, input int per, input bit use_free, input bit toggle_other);
    for (int i = 0; i < n; i++) begin
      if (use_free) begin
        nx_free = (i % per) == 0;
        nx_scan = toggle_other ? ((i / 3) % 2 == 1) : 1'b0;
      end else begin
        nx_scan = (i % per) == 0;
        nx_free = toggle_other ? ((i / 3) % 2 == 1) : 1'b0;
      end
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    nx_rst = 0; nx_dig = 16'h4321;
    repeat (3) step();
    nx_rst = 1;
    step();
    @(negedge clk); #1;
    chk("R1 reset digit", dig_en, 4'b1000);
    chk("R1 reset nibble", bcd_out, 4);
    // R2 R3 R5 R6: normal scanning, free_tick toggling and ignored
    run(130, 26, 0, 1);
    nx_dig = 16'h9807;
    run(130, 26, 0, 0);
    // R6: every code, including 10..15
    for (int v = 0; v < 16; v++) begin
      nx_dig = {4{4'(v)}};
      run(8, 4, 0, 0);
    end
    // R4: pulse held high many cycles
    nx_dig = 16'h5678;
    for (int r = 0; r < 3; r++) begin
      nx_scan = 1; repeat (10) step();
      nx_scan = 0; repeat (5) step();
    end
    // R7: display off freezes, then resumes
    nx_off = 1; run(60, 5, 0, 0);
    nx_off = 0; run(40, 6, 0, 0);
    // R8: load mode follows free_tick, scan_tick ignored
    nx_load = 1; nx_dig = 16'h2468;
    run(110, 26, 1, 1);
    run(30, 7, 1, 0);
    nx_load = 0; run(60, 9, 0, 0);
    // R1: reset mid-run
    nx_rst = 0; step(); nx_rst = 1; nx_scan = 0; nx_free = 0; step();
    chk("R1 mid-run reset", dig_en, 4'b1000);
    run(50, 5, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule